// File: doc/BRIEF.md
# Display Refresh, Dimming and Flash Timer

This block derives all display-side timing from one display clock. A slot counter divides each refresh frame into eight equal 28-clock slots, one per character position, and exposes the active position as a scan index. Within each slot a dot-drive enable is held high for a number of clocks set by a 3-bit intensity code. The dark code switches the drive off entirely.

A second counter produces a slow two-phase flash cycle. Each digit's visible flag is formed from that phase, a per-digit attribute vector, a global flash enable and a global blink enable. Blink takes priority over per-digit flash.

A synchronous reset returns every counter to zero. Several units that share one clock and one reset therefore scan and blink in step. Character decoding and the LED drivers sit outside this block and consume the three outputs.

Top module: `disp_refresh_timer`

## Requirements
- R1: `scan_idx` is 0 after reset. Each index value is held for 28 clocks and then increments. The index wraps from 7 back to 0, so one full frame is 224 clocks. Counting k as the number of clock edges since reset was released, `scan_idx` = (k/28) mod 8.
- R2: Within each slot, `dot_en` is high at slot positions p = k mod 28 with p < N and low otherwise. N is taken from `bright_code`: 0→28, 1→22, 2→15, 3→11, 4→8, 5→6, 6→4. These values are 28 × {100, 80, 53, 40, 27, 20, 13} % rounded to the nearest clock.
- R3: `bright_code` = 7 keeps `dot_en` low at every position. Code 0 keeps it high at every position.
- R4: The flash cycle is 28,672 clocks long. Positions 0 to 14,335 of k mod 28,672 form the on phase, and positions 14,336 to 28,671 form the off phase.
- R5: When `flash_en` = 1 and `blink_en` = 0, `digit_vis[d]` is 0 during the off phase exactly for the digits whose `flash_attr[d]` = 1. All other flags stay 1.
- R6: When `flash_en` = 0 and `blink_en` = 0, `flash_attr` has no effect and `digit_vis` is all ones in both phases.
- R7: When `blink_en` = 1, all eight flags are 0 in the off phase and 1 in the on phase, whatever the values of `flash_en` and `flash_attr`.
- R8: `rst` is synchronous and active high. While it is sampled high, the counters clear, `scan_idx` = 0, `dot_en` = 0 and `digit_vis` = all ones. Counting restarts from k = 0 when it is released.
- R9: `bright_code`, `flash_en`, `blink_en` and `flash_attr` are sampled at a clock edge. They take effect in the output values registered at that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Display clock |
| rst | input | 1 | Synchronous active-high reset |
| bright_code | input | 3 | Intensity code; 0 brightest, 7 dark |
| flash_en | input | 1 | Global enable for per-digit flash attributes |
| blink_en | input | 1 | Global blink of all digits; overrides flash |
| flash_attr | input | 8 | Per-digit flash attribute, bit d for digit d |
| scan_idx | output | 3 | Character position currently being driven |
| digit_vis | output | 8 | Per-digit visible flag |
| dot_en | output | 1 | Dot-drive enable for the current slot |

## Verification
All three outputs are registered, so a control input sampled at edge k shows up in the outputs that settle after edge k. There is a single cycle of latency and no extra pipeline stage. The bench reference model advances its own edge count k on every rising edge and reads the inputs at that edge to form the expected scan index, dot enable and visible flags. It compares them with the design on the following falling edge, when both the design's outputs and the stimulus are stable. Stimulus changes only on falling edges, after that comparison. An input change therefore lands exactly one sample before its effect is expected, including mid-slot intensity changes and mode changes deep inside the off phase.

// File: rtl/disp_timing_pkg.sv
package disp_timing_pkg;

  // Relative intensity in percent for each code; code 7 is dark.
  function automatic int unsigned level_pct(input logic [2:0] code);
    int unsigned pct;
    case (code)
      3'd0:    pct = 100;
      3'd1:    pct = 80;
      3'd2:    pct = 53;
      3'd3:    pct = 40;
      3'd4:    pct = 27;
      3'd5:    pct = 20;
      3'd6:    pct = 13;
      default: pct = 0;
    endcase
    return pct;
  endfunction

  // Number of lit clocks in a slot, rounded to the nearest whole clock.
  function automatic int unsigned lit_clocks(input logic [2:0] code,
                                             input int unsigned slot_len);
    return (slot_len * level_pct(code) + 50) / 100;
  endfunction

endpackage

// File: rtl/scan_timer.sv
module scan_timer #(
  parameter int unsigned NUM_DIGITS = 8,
  parameter int unsigned SLOT_CLKS  = 28,
  localparam int unsigned SLOT_W    = $clog2(SLOT_CLKS),
  localparam int unsigned DIG_W     = $clog2(NUM_DIGITS)
) (
  input  logic              clk,
  input  logic              rst,
  output logic [SLOT_W-1:0] slot_nxt,
  output logic [DIG_W-1:0]  digit_q
);

  logic [SLOT_W-1:0] slot_q;
  logic [DIG_W-1:0]  digit_nxt;
  logic              slot_wrap;

  always_comb begin
    slot_wrap = (slot_q == SLOT_W'(SLOT_CLKS - 1));
    slot_nxt  = slot_wrap ? '0 : slot_q + 1'b1;
    digit_nxt = digit_q;
    if (slot_wrap)
      digit_nxt = (digit_q == DIG_W'(NUM_DIGITS - 1)) ? '0 : digit_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_q  <= '0;
      digit_q <= '0;
    end else begin
      slot_q  <= slot_nxt;
      digit_q <= digit_nxt;
    end
  end

  // R1: slot position stays inside one slot
  p_slot_range_r1: assert property (@(posedge clk) disable iff (rst)
    slot_q < SLOT_W'(SLOT_CLKS));

  // R1: the scan index only moves at the end of a slot
  p_digit_hold_r1: assert property (@(posedge clk) disable iff (rst)
    (slot_q != SLOT_W'(SLOT_CLKS - 1)) |=> $stable(digit_q));

endmodule

// File: rtl/flash_timer.sv
module flash_timer #(
  parameter int unsigned FLASH_PERIOD = 28672,
  localparam int unsigned FL_W        = $clog2(FLASH_PERIOD),
  localparam int unsigned HALF        = FLASH_PERIOD / 2
) (
  input  logic clk,
  input  logic rst,
  output logic off_nxt
);

  logic [FL_W-1:0] cnt_q;
  logic [FL_W-1:0] cnt_nxt;

  always_comb begin
    cnt_nxt = (cnt_q == FL_W'(FLASH_PERIOD - 1)) ? '0 : cnt_q + 1'b1;
    off_nxt = (cnt_nxt >= FL_W'(HALF));
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_nxt;
  end

  // R4: the flash counter never leaves its period
  p_flash_range_r4: assert property (@(posedge clk) disable iff (rst)
    cnt_q < FL_W'(FLASH_PERIOD));

  // R4: the last position of the cycle is followed by position zero
  p_flash_wrap_r4: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == FL_W'(FLASH_PERIOD - 1)) |=> (cnt_q == '0));

endmodule

// File: rtl/drive_gate.sv
module drive_gate
  import disp_timing_pkg::*;
#(
  parameter int unsigned NUM_DIGITS = 8,
  parameter int unsigned SLOT_CLKS  = 28,
  localparam int unsigned SLOT_W    = $clog2(SLOT_CLKS)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [SLOT_W-1:0]     slot_nxt,
  input  logic                  off_nxt,
  input  logic [2:0]            bright_code,
  input  logic                  flash_en,
  input  logic                  blink_en,
  input  logic [NUM_DIGITS-1:0] flash_attr,
  output logic                  dot_en,
  output logic [NUM_DIGITS-1:0] digit_vis
);

  logic lit_nxt;

  always_comb lit_nxt = (32'(slot_nxt) < lit_clocks(bright_code, SLOT_CLKS));

  always_ff @(posedge clk) begin
    if (rst) dot_en <= 1'b0;
    else     dot_en <= lit_nxt;
  end

  for (genvar d = 0; d < NUM_DIGITS; d++) begin : g_digit
    logic hide;
    always_comb begin
      if (blink_en) hide = off_nxt;
      else          hide = flash_en & flash_attr[d] & off_nxt;
    end
    always_ff @(posedge clk) begin
      if (rst) digit_vis[d] <= 1'b1;
      else     digit_vis[d] <= ~hide;
    end
  end

endmodule

// File: rtl/disp_refresh_timer.sv
module disp_refresh_timer #(
  parameter int unsigned NUM_DIGITS   = 8,
  parameter int unsigned SLOT_CLKS    = 28,
  parameter int unsigned FLASH_PERIOD = 28672,
  localparam int unsigned SLOT_W      = $clog2(SLOT_CLKS),
  localparam int unsigned DIG_W       = $clog2(NUM_DIGITS)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [2:0]            bright_code,
  input  logic                  flash_en,
  input  logic                  blink_en,
  input  logic [NUM_DIGITS-1:0] flash_attr,
  output logic [DIG_W-1:0]      scan_idx,
  output logic [NUM_DIGITS-1:0] digit_vis,
  output logic                  dot_en
);

  logic [SLOT_W-1:0] slot_nxt;
  logic              off_nxt;

  scan_timer #(.NUM_DIGITS(NUM_DIGITS), .SLOT_CLKS(SLOT_CLKS)) u_scan (
    .clk      (clk),
    .rst      (rst),
    .slot_nxt (slot_nxt),
    .digit_q  (scan_idx)
  );

  flash_timer #(.FLASH_PERIOD(FLASH_PERIOD)) u_flash (
    .clk     (clk),
    .rst     (rst),
    .off_nxt (off_nxt)
  );

  drive_gate #(.NUM_DIGITS(NUM_DIGITS), .SLOT_CLKS(SLOT_CLKS)) u_gate (
    .clk         (clk),
    .rst         (rst),
    .slot_nxt    (slot_nxt),
    .off_nxt     (off_nxt),
    .bright_code (bright_code),
    .flash_en    (flash_en),
    .blink_en    (blink_en),
    .flash_attr  (flash_attr),
    .dot_en      (dot_en),
    .digit_vis   (digit_vis)
  );

  // R3: the dark code keeps the dot drive off
  p_blank_r3: assert property (@(posedge clk) disable iff (rst)
    (bright_code == 3'd7) |=> !dot_en);

  // R3: the brightest code keeps the dot drive on
  p_full_r3: assert property (@(posedge clk) disable iff (rst)
    (bright_code == 3'd0) |=> dot_en);

  // R6: with both global enables off, attributes cannot hide a digit
  p_attr_ignored_r6: assert property (@(posedge clk) disable iff (rst)
    (!flash_en && !blink_en) |=> (digit_vis == '1));

  // R7: blink moves all digits together
  p_blink_uniform_r7: assert property (@(posedge clk) disable iff (rst)
    blink_en |=> ((digit_vis == '0) || (digit_vis == '1)));

endmodule

// File: tb/sim_disp_refresh_timer.sv
module sim_disp_refresh_timer;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] bright_code = 3'd0;
  logic       flash_en = 1'b0;
  logic       blink_en = 1'b0;
  logic [7:0] flash_attr = 8'h00;
  logic [2:0] scan_idx;
  logic [7:0] digit_vis;
  logic       dot_en;

  int checks = 0;
  int errors = 0;
  int k = 0;
  bit started = 1'b0;
  bit finished = 1'b0;
  int on_tab [8] = '{28, 22, 15, 11, 8, 6, 4, 0};

  logic [2:0] exp_scan;
  logic [7:0] exp_vis;
  logic       exp_dot;
  string      tag_dot;
  string      tag_vis;
  bit         exp_rst;

  always #10 clk = ~clk;

  disp_refresh_timer u0 (
    .clk(clk), .rst(rst), .bright_code(bright_code), .flash_en(flash_en),
    .blink_en(blink_en), .flash_attr(flash_attr), .scan_idx(scan_idx),
    .digit_vis(digit_vis), .dot_en(dot_en)
  );

  // Reference model: edge count since reset release and inputs at that edge.
  always @(posedge clk) begin
    bit off;
    started <= 1'b1;
    if (rst) begin
      k = 0;
      exp_rst  = 1'b1;
      exp_scan = 3'd0;
      exp_dot  = 1'b0;
      exp_vis  = 8'hFF;
    end else begin
      k = k + 1;
      exp_rst  = 1'b0;
      exp_scan = 3'((k / 28) % 8);
      exp_dot  = ((k % 28) < on_tab[bright_code]);
      tag_dot  = (bright_code == 3'd0 || bright_code == 3'd7) ? "R3 R9" : "R2 R9";
      off = ((k % 28672) >= 14336);
      if (blink_en) begin
        exp_vis = off ? 8'h00 : 8'hFF;
        tag_vis = "R7 R4";
      end else if (flash_en) begin
        exp_vis = off ? ~flash_attr : 8'hFF;
        tag_vis = "R5 R4";
      end else begin
        exp_vis = 8'hFF;
        tag_vis = "R6";
      end
    end
  end

  always @(negedge clk) begin
    if (started && !finished) begin
      checks++;
      if (scan_idx !== exp_scan) begin
        errors++;
        $display("FAIL %s scan_idx k=%0d actual=%0d expected=%0d",
                 exp_rst ? "R8" : "R1", k, scan_idx, exp_scan);
      end
      checks++;
      if (dot_en !== exp_dot) begin
        errors++;
        $display("FAIL %s dot_en k=%0d code=%0d actual=%0b expected=%0b",
                 exp_rst ? "R8" : tag_dot, k, bright_code, dot_en, exp_dot);
      end
      checks++;
      if (digit_vis !== exp_vis) begin
        errors++;
        $display("FAIL %s digit_vis k=%0d actual=%h expected=%h",
                 exp_rst ? "R8" : tag_vis, k, digit_vis, exp_vis);
      end
    end
  end

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    run(3);
    rst = 1'b0;                       // R8 reset state checked above
    run(448);                         // R1 two full frames, R3 code 0
    for (int c = 1; c < 8; c++) begin // R2 every code, changed mid-slot
      bright_code = 3'(c);
      run(61);
    end
    bright_code = 3'd2;
    flash_en = 1'b1;
    flash_attr = 8'hA5;               // R5 across the on/off boundary
    run(16000);
    flash_en = 1'b0;
    flash_attr = 8'hFF;               // R6 attributes ignored in off phase
    run(300);
    blink_en = 1'b1;
    flash_en = 1'b1;
    flash_attr = 8'h0F;               // R7 blink overrides flash
    run(300);
    blink_en = 1'b0;
    flash_attr = 8'h3C;
    run(13000);                       // R4 wrap back into the on phase
    blink_en = 1'b1;
    bright_code = 3'd7;
    run(16000);                       // R7 blink on->off, R3 dark
    rst = 1'b1;                       // R8 mid-run reset
    run(2);
    rst = 1'b0;
    bright_code = 3'd4;
    blink_en = 1'b0;
    run(500);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule